// File: doc/BRIEF.md
# Per-Process Paging Translation Unit

This block maps 20-bit logical word addresses to 20-bit physical word addresses. Each address selects one 16-bit word. The upper ten bits form the page number and the lower ten bits form the offset within a 1K-word page frame. The page tables do not live in main memory. They sit in storage inside the block, one table for each of up to 64 processes, and a 6-bit current-process input picks the table that is used.

A mode input chooses between two behaviours. In Real mode the address passes through unchanged and no check is made. In Protected mode the block reads the selected entry and checks that it is valid. It then checks the access against the entry's supervisor and writable marks. The result is either a translated address, a page fault or a protection fault. The translated result also reports whether the frame is supervisor-marked, so the instruction path can decide whether privileged instructions may run. Table entries are loaded through a write port that only accepts writes while a supervisor-privilege input is high.

To bound storage, each process table covers the lowest 2^TBL_PAGE_W pages; the default is 32 pages. A page number above that range always faults in Protected mode.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, out_valid, page_fault, prot_fault and out_super are low, and every table entry of every process reads as not valid.
- R2: A request (req_valid high at a rising edge) produces its result at the next rising edge, and the result lasts one cycle. A cycle with no request gives all of out_valid, page_fault, prot_fault and out_super low in the next cycle.
- R3: With prot_mode low, a request gives out_valid high, out_addr equal to req_addr, no fault, and out_super low, whatever the table holds.
- R4: With prot_mode high and an access that passes its checks, out_valid is high and out_addr is {entry frame, req_addr[9:0]}. out_super equals the entry's supervisor bit. The entry layout is: bits 9:0 frame, bit 10 valid, bit 11 supervisor, bit 12 writable.
- R5: In Protected mode, an entry whose valid bit (bit 10) is clear gives page_fault high and out_valid low.
- R6: In Protected mode, a page number of 2^TBL_PAGE_W (32 by default) or more gives page_fault, and table writes to such pages are ignored.
- R7: In Protected mode, a request with req_super low to an entry whose supervisor bit (bit 11) is set gives prot_fault high and out_valid low.
- R8: In Protected mode, a request with req_write high to an entry whose writable bit (bit 12) is clear gives prot_fault. A read of the same entry translates normally.
- R9: Each Protected-mode request raises exactly one of out_valid, page_fault and prot_fault. A page fault takes precedence over a protection fault.
- R10: A table write (tw_en high) is applied only if tw_priv is high in the same cycle. Otherwise it leaves the table unchanged.
- R11: The tables of different processes are independent. A write to (tw_pid, page) does not change what any other process reads for that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_mode | input | 1 | 1 = Protected mode, 0 = Real mode (bypass) |
| cur_pid | input | 6 | Current process number, selects the table |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 20 | Logical word address |
| req_write | input | 1 | Request is a write access |
| req_super | input | 1 | Request is issued with supervisor privilege |
| tw_en | input | 1 | Table write strobe |
| tw_priv | input | 1 | Supervisor privilege qualifying the table write |
| tw_pid | input | 6 | Process whose table is written |
| tw_page | input | 10 | Page number written |
| tw_entry | input | 13 | Entry data (frame, valid, supervisor, writable) |
| out_valid | output | 1 | Translated address is valid |
| out_addr | output | 20 | Physical word address, meaningful when out_valid is high |
| out_super | output | 1 | Translated frame carries the supervisor mark |
| page_fault | output | 1 | One-cycle page fault pulse |
| prot_fault | output | 1 | One-cycle protection fault pulse |

## Verification
The hardest case to reach from the ports is a Protected-mode request that hits an entry that was really loaded for the current process. With 2048 entries, random addresses nearly always land on empty slots and only test the page-fault path. The stimulus therefore limits random process numbers to a few values, including the top one, 63. It keeps most page numbers below the implemented range and mixes random table writes, both privileged and unprivileged, into the request stream. In this way valid, supervisor-marked and read-only entries get hit repeatedly. Directed cases cover the ordering of faults, the boundary at page 32, and the isolation between processes.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

   // outcome of one translation
   typedef enum logic [1:0] {
      RES_IDLE  = 2'd0,
      RES_OK    = 2'd1,
      RES_PGFLT = 2'd2,
      RES_PRFLT = 2'd3
   } xlate_res_e;

   // entry field offsets relative to frame width
   function automatic int vld_pos(input int frame_w);
      return frame_w;
   endfunction

   function automatic int sup_pos(input int frame_w);
      return frame_w + 1;
   endfunction

   function automatic int wr_pos(input int frame_w);
      return frame_w + 2;
   endfunction

endpackage

// File: rtl/pxu_table.sv
module pxu_table #(
   parameter int PID_W      = 6,
   parameter int TBL_PAGE_W = 5,
   parameter int FRAME_W    = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [PID_W-1:0]      w_pid,
   input  logic [TBL_PAGE_W-1:0] w_page,
   input  logic [FRAME_W-1:0]    w_frame,
   input  logic                  w_vld,
   input  logic                  w_sup,
   input  logic                  w_wr,
   input  logic [PID_W-1:0]      r_pid,
   input  logic [TBL_PAGE_W-1:0] r_page,
   output logic [FRAME_W-1:0]    r_frame,
   output logic                  r_vld,
   output logic                  r_sup,
   output logic                  r_wr
);

   localparam int IDX_W  = PID_W + TBL_PAGE_W;
   localparam int DEPTH  = 1 << IDX_W;
   localparam int ATTR_W = FRAME_W + 2;

   logic [DEPTH-1:0]  vld_q;
   logic [ATTR_W-1:0] attr_mem [DEPTH];
   logic [IDX_W-1:0]  w_idx;
   logic [IDX_W-1:0]  r_idx;
   logic [ATTR_W-1:0] r_attr;

   assign w_idx = {w_pid, w_page};
   assign r_idx = {r_pid, r_page};

   // only the valid bits need reset; the rest is don't-care until valid
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (we) begin
         vld_q[w_idx] <= w_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (we) begin
         attr_mem[w_idx] <= {w_wr, w_sup, w_frame};
      end
   end

   assign r_attr  = attr_mem[r_idx];
   assign r_vld   = vld_q[r_idx];
   assign r_frame = r_attr[FRAME_W-1:0];
   assign r_sup   = r_attr[FRAME_W];
   assign r_wr    = r_attr[FRAME_W+1];

endmodule

// File: rtl/pxu_check.sv
module pxu_check
   import pxu_pkg::*;
#(
   parameter int PAGE_W     = 10,
   parameter int TBL_PAGE_W = 5
) (
   input  logic              req,
   input  logic              prot,
   input  logic              is_wr,
   input  logic              acc_sup,
   input  logic [PAGE_W-1:0] page,
   input  logic              e_vld,
   input  logic              e_sup,
   input  logic              e_wr,
   output xlate_res_e        res
);

   logic in_range;
   logic priv_bad;
   logic wr_bad;

   generate
      if (TBL_PAGE_W < PAGE_W) begin : g_range
         assign in_range = (page[PAGE_W-1:TBL_PAGE_W] == '0);
      end else begin : g_full
         assign in_range = 1'b1;
      end
   endgenerate

   assign priv_bad = e_sup & ~acc_sup;
   assign wr_bad   = is_wr & ~e_wr;

   always_comb begin
      if (!req) begin
         res = RES_IDLE;
      end else if (!prot) begin
         res = RES_OK;
      end else if (!in_range || !e_vld) begin
         res = RES_PGFLT;
      end else if (priv_bad || wr_bad) begin
         res = RES_PRFLT;
      end else begin
         res = RES_OK;
      end
   end

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
   import pxu_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int OFS_W      = 10,
   parameter int PID_W      = 6,
   parameter int TBL_PAGE_W = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    prot_mode,
   input  logic [PID_W-1:0]        cur_pid,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic                    req_write,
   input  logic                    req_super,
   input  logic                    tw_en,
   input  logic                    tw_priv,
   input  logic [PID_W-1:0]        tw_pid,
   input  logic [ADDR_W-OFS_W-1:0] tw_page,
   input  logic [ADDR_W-OFS_W+2:0] tw_entry,
   output logic                    out_valid,
   output logic [ADDR_W-1:0]       out_addr,
   output logic                    out_super,
   output logic                    page_fault,
   output logic                    prot_fault
);

   localparam int PAGE_W  = ADDR_W - OFS_W;
   localparam int FRAME_W = PAGE_W;
   localparam int V_POS   = vld_pos(FRAME_W);
   localparam int S_POS   = sup_pos(FRAME_W);
   localparam int W_POS   = wr_pos(FRAME_W);

   generate
      if (OFS_W < 1 || OFS_W >= ADDR_W) begin : g_bad_ofs
         $error("page_xlate_unit: OFS_W must lie in 1..ADDR_W-1");
      end
      if (TBL_PAGE_W < 1 || TBL_PAGE_W > PAGE_W) begin : g_bad_tbl
         $error("page_xlate_unit: TBL_PAGE_W must lie in 1..PAGE_W");
      end
      if (PID_W < 1) begin : g_bad_pid
         $error("page_xlate_unit: PID_W must be at least 1");
      end
   endgenerate

   logic [PAGE_W-1:0]  req_page;
   logic [OFS_W-1:0]   req_ofs;
   logic               tw_in_range;
   logic               tbl_we;
   logic [FRAME_W-1:0] e_frame;
   logic               e_vld;
   logic               e_sup;
   logic               e_wr;
   xlate_res_e         res;
   logic [ADDR_W-1:0]  xl_addr;

   assign req_page = req_addr[ADDR_W-1:OFS_W];
   assign req_ofs  = req_addr[OFS_W-1:0];

   // table writes outside the implemented page range are dropped
   generate
      if (TBL_PAGE_W < PAGE_W) begin : g_tw_range
         assign tw_in_range = (tw_page[PAGE_W-1:TBL_PAGE_W] == '0);
      end else begin : g_tw_full
         assign tw_in_range = 1'b1;
      end
   endgenerate

   assign tbl_we = tw_en & tw_priv & tw_in_range;

   pxu_table #(
      .PID_W     (PID_W),
      .TBL_PAGE_W(TBL_PAGE_W),
      .FRAME_W   (FRAME_W)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (tbl_we),
      .w_pid  (tw_pid),
      .w_page (tw_page[TBL_PAGE_W-1:0]),
      .w_frame(tw_entry[FRAME_W-1:0]),
      .w_vld  (tw_entry[V_POS]),
      .w_sup  (tw_entry[S_POS]),
      .w_wr   (tw_entry[W_POS]),
      .r_pid  (cur_pid),
      .r_page (req_page[TBL_PAGE_W-1:0]),
      .r_frame(e_frame),
      .r_vld  (e_vld),
      .r_sup  (e_sup),
      .r_wr   (e_wr)
   );

   pxu_check #(
      .PAGE_W    (PAGE_W),
      .TBL_PAGE_W(TBL_PAGE_W)
   ) u_check (
      .req    (req_valid),
      .prot   (prot_mode),
      .is_wr  (req_write),
      .acc_sup(req_super),
      .page   (req_page),
      .e_vld  (e_vld),
      .e_sup  (e_sup),
      .e_wr   (e_wr),
      .res    (res)
   );

   assign xl_addr = prot_mode ? {e_frame, req_ofs} : req_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_addr   <= '0;
         out_super  <= 1'b0;
         page_fault <= 1'b0;
         prot_fault <= 1'b0;
      end else begin
         out_valid  <= (res == RES_OK);
         page_fault <= (res == RES_PGFLT);
         prot_fault <= (res == RES_PRFLT);
         out_super  <= (res == RES_OK) & prot_mode & e_sup;
         if (res == RES_OK) begin
            out_addr <= xl_addr;
         end
      end
   end

endmodule

// File: rtl/pxu_chk.sv
module pxu_chk #(
   parameter int ADDR_W = 20,
   parameter int OFS_W  = 10,
   parameter int PID_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prot_mode,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              out_valid,
   input logic [ADDR_W-1:0] out_addr,
   input logic              out_super,
   input logic              page_fault,
   input logic              prot_fault
);

   // R9
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_valid, page_fault, prot_fault}));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid && !page_fault && !prot_fault && !out_super);

   // R3
   bypass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !prot_mode) |=> out_valid && out_addr == $past(req_addr) && !out_super);

   // R3
   bypass_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !prot_mode) |=> !page_fault && !prot_fault);

   // R9
   prot_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prot_mode) |=> $countones({out_valid, page_fault, prot_fault}) == 1);

   // R4
   offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]));

   // R4
   super_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_super |-> out_valid);

endmodule

bind page_xlate_unit pxu_chk #(
   .ADDR_W(ADDR_W),
   .OFS_W (OFS_W),
   .PID_W (PID_W)
) u_pxu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .prot_mode (prot_mode),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .out_valid (out_valid),
   .out_addr  (out_addr),
   .out_super (out_super),
   .page_fault(page_fault),
   .prot_fault(prot_fault)
);

// File: tb/page_xlate_unit_tb.sv
module page_xlate_unit_tb;

   localparam int NPAGE = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prot_mode = 1'b0;
   logic [5:0]  cur_pid = '0;
   logic        req_valid = 1'b0;
   logic [19:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_super = 1'b0;
   logic        tw_en = 1'b0;
   logic        tw_priv = 1'b0;
   logic [5:0]  tw_pid = '0;
   logic [9:0]  tw_page = '0;
   logic [12:0] tw_entry = '0;
   logic        out_valid;
   logic [19:0] out_addr;
   logic        out_super;
   logic        page_fault;
   logic        prot_fault;

   int n_run = 0;
   int n_bad = 0;
   logic [12:0] ref_tab [64*NPAGE];

   page_xlate_unit u_dut (
      .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .cur_pid(cur_pid),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_super(req_super), .tw_en(tw_en), .tw_priv(tw_priv), .tw_pid(tw_pid),
      .tw_page(tw_page), .tw_entry(tw_entry), .out_valid(out_valid),
      .out_addr(out_addr), .out_super(out_super), .page_fault(page_fault),
      .prot_fault(prot_fault)
   );

   always #5 clk = ~clk;

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   // {super, prot_fault, page_fault, valid, addr}
   function automatic logic [23:0] predict(input logic [5:0] pid, input logic [19:0] a,
                                            input logic wr, input logic sup, input logic prot);
      logic [12:0] e;
      if (!prot) return {4'b0001, a};
      if (a[19:10] >= NPAGE) return {4'b0010, 20'h0};
      e = ref_tab[pid*NPAGE + int'(a[19:10])];
      if (!e[10]) return {4'b0010, 20'h0};
      if ((!sup && e[11]) || (wr && !e[12])) return {4'b0100, 20'h0};
      return {e[11], 3'b001, e[9:0], a[9:0]};
   endfunction

   function automatic string tag_of(input logic [23:0] x, input logic [19:0] a,
                                    input logic prot, input logic sup,
                                    input logic [5:0] pid);
      if (!prot) return "R3";
      if (x[21]) return (a[19:10] >= NPAGE) ? "R6" : "R5";
      if (x[22]) return (!sup && ref_tab[pid*NPAGE + int'(a[19:10])][11]) ? "R7" : "R8";
      return "R4";
   endfunction

   task automatic tbl_write(input logic [5:0] pid, input logic [9:0] pg,
                            input logic [12:0] e, input logic priv);
      @(negedge clk);
      tw_en = 1'b1; tw_priv = priv; tw_pid = pid; tw_page = pg; tw_entry = e;
      @(negedge clk);
      tw_en = 1'b0; tw_priv = 1'b0;
      // R10 R6: model updates only for privileged, in-range writes
      if (priv && pg < NPAGE) ref_tab[pid*NPAGE + int'(pg)] = e;
   endtask

   task automatic lookup(input logic [5:0] pid, input logic [19:0] a, input logic wr,
                         input logic sup, input logic prot, input string tag);
      logic [23:0] exp_v;
      logic [23:0] got;
      exp_v = predict(pid, a, wr, sup, prot);
      @(negedge clk);
      cur_pid = pid; req_addr = a; req_write = wr; req_super = sup;
      prot_mode = prot; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      got = {out_super, prot_fault, page_fault, out_valid, out_valid ? out_addr : 20'h0};
      n_run++;
      if (got !== exp_v) begin
         n_bad++;
         $display("FAIL %s: pid=%0d addr=%h got %h expected %h", tag, pid, a, got, exp_v);
      end
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      n_run++;
      if ({out_valid, page_fault, prot_fault, out_super} !== 4'b0) begin
         n_bad++;
         $display("FAIL %s: idle outputs got %b expected 0000", tag,
                  {out_valid, page_fault, prot_fault, out_super});
      end
   endtask

   initial begin
      for (int i = 0; i < 64*NPAGE; i++) ref_tab[i] = '0;
      void'($urandom(32'h1357_2468));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: outputs low and tables empty after reset
      idle_check("R1");
      lookup(6'd0, 20'h00000, 1'b0, 1'b1, 1'b1, "R1");
      lookup(6'd63, 20'h07c00, 1'b0, 1'b1, 1'b1, "R1");

      // R10: unprivileged write ignored, privileged write taken
      tbl_write(6'd5, 10'd3, {3'b101, 10'h2a5}, 1'b0);
      lookup(6'd5, {10'd3, 10'h011}, 1'b0, 1'b0, 1'b1, "R10");
      tbl_write(6'd5, 10'd3, {3'b101, 10'h2a5}, 1'b1);
      lookup(6'd5, {10'd3, 10'h011}, 1'b0, 1'b0, 1'b1, "R4");
      lookup(6'd5, {10'd3, 10'h3ff}, 1'b1, 1'b0, 1'b1, "R4");
      // R2: cycle after a result with no request is quiet
      idle_check("R2");

      // R11: another process sees nothing at the same page
      lookup(6'd6, {10'd3, 10'h011}, 1'b0, 1'b0, 1'b1, "R11");

      // R3: real mode passthrough regardless of table
      lookup(6'd6, 20'habcde, 1'b1, 1'b0, 1'b0, "R3");
      lookup(6'd5, {10'd3, 10'h011}, 1'b0, 1'b0, 1'b0, "R3");

      // R6: boundary page 31 in range, 32 out of range
      tbl_write(6'd1, 10'd31, {3'b101, 10'h3c3}, 1'b1);
      lookup(6'd1, {10'd31, 10'h001}, 1'b0, 1'b0, 1'b1, "R6");
      tbl_write(6'd1, 10'd32, {3'b101, 10'h111}, 1'b1);
      lookup(6'd1, {10'd32, 10'h001}, 1'b0, 1'b1, 1'b1, "R6");
      lookup(6'd1, 20'hfffff, 1'b0, 1'b1, 1'b1, "R6");
      // R6: out-of-range write must not alias onto page 0
      lookup(6'd1, {10'd0, 10'h001}, 1'b0, 1'b1, 1'b1, "R6");

      // R7: supervisor frame
      tbl_write(6'd2, 10'd7, {3'b111, 10'h155}, 1'b1);
      lookup(6'd2, {10'd7, 10'h020}, 1'b0, 1'b0, 1'b1, "R7");
      lookup(6'd2, {10'd7, 10'h020}, 1'b0, 1'b1, 1'b1, "R7");

      // R8: read-only frame
      tbl_write(6'd2, 10'd8, {3'b001, 10'h0f0}, 1'b1);
      lookup(6'd2, {10'd8, 10'h100}, 1'b1, 1'b1, 1'b1, "R8");
      lookup(6'd2, {10'd8, 10'h100}, 1'b0, 1'b0, 1'b1, "R8");

      // R9: invalid entry with bad privilege reports page fault only
      tbl_write(6'd2, 10'd9, {3'b010, 10'h0f0}, 1'b1);
      lookup(6'd2, {10'd9, 10'h005}, 1'b1, 1'b0, 1'b1, "R9");

      // R5: entry invalidated by rewrite
      tbl_write(6'd5, 10'd3, {3'b100, 10'h2a5}, 1'b1);
      lookup(6'd5, {10'd3, 10'h011}, 1'b0, 1'b0, 1'b1, "R5");

      // random mix
      for (int k = 0; k < 600; k++) begin
         logic [5:0]  pid;
         logic [19:0] a;
         logic [23:0] px;
         case ($urandom_range(0, 3))
            0: pid = 6'd0;
            1: pid = 6'd1;
            2: pid = 6'd2;
            default: pid = 6'd63;
         endcase
         a = {10'($urandom_range(0, 39)), 10'($urandom)};
         if ($urandom_range(0, 2) == 0) begin
            tbl_write(pid, a[19:10], 13'($urandom) | 13'h0400 * 13'($urandom_range(0, 1)),
                      1'($urandom_range(0, 3) != 0));
         end else begin
            logic wr, sup, prot;
            wr   = 1'($urandom);
            sup  = 1'($urandom);
            prot = ($urandom_range(0, 4) != 0);
            px   = predict(pid, a, wr, sup, prot);
            lookup(pid, a, wr, sup, prot, tag_of(px, a, prot, sup, pid));
         end
      end

      idle_check("R2");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule